// File: doc/BRIEF.md
# PHY Management Register Access Unit

This block is a single 32-bit management control word that a host writes to start a read or write cycle on a set of PHY registers. The PHY register array, 32 PHY addresses by 32 registers of 16 bits, is held inside the block. The serial management wire protocol and any real PHY are not modelled. A write to the control word starts a cycle. The cycle finishes a fixed number of clocks later. On completion the ready bit returns, read data appears in the low half of the word, and a one-cycle status event fires.

Some register numbers do not return stored contents on a read. They return fixed identity and capability constants, for any PHY address. Register 0 is altered on its way out: two control bits are masked off and a speed bit is forced on. An interrupt-enable bit in the issuing word decides whether completion also pulses an interrupt output.

Top module: `mgmt_access_unit`

## Requirements
- R1: After reset, ctrl_o reads 0x1000_0000 (only ready set), stat_evt_o and irq_o are low, and every stored PHY register holds 0.
- R2: A write on wr_en_i captures the word with this layout: bit 29 interrupt enable, bits 27:26 opcode, bits 25:21 PHY address, bits 20:16 register number, bits 15:0 data. Bits 31:30 read 0. Ready (bit 28) reads 0 in the cycle after the write.
- R3: Ready sets exactly LATENCY (default 4) clock edges after the edge that captured the write. It stays low before that.
- R4: Opcode 1 (write) stores bits 15:0 into the addressed register of the addressed PHY. The data field of ctrl_o keeps the written value.
- R5: Opcode 2 (read) of any register number other than 0, 1, 2, 3, 5, 6 and 17 puts the stored value in bits 15:0 at completion.
- R6: A read of register 0 returns the stored value with bits 15 and 9 cleared and bit 13 set.
- R7: Reads of registers 1, 2, 3, 5, 6 and 17 return 0x782C, 0x0013, 0x61D4, 0x41E1, 0x0001 and 0x4700 respectively, for any PHY address and any stored value.
- R8: Every completed cycle pulses stat_evt_o high for exactly one cycle, in the first cycle that ready reads 1.
- R9: irq_o pulses together with stat_evt_o only if bit 29 was set in the issuing word. Otherwise it stays low.
- R10: Opcodes 0 and 3 complete normally but change no register. The word, with ready set, is returned unchanged.
- R11: A new write while a cycle is pending abandons the pending cycle without any register update or event, and restarts the timer for the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host write strobe for the control word |
| wr_data_i | input | 32 | Control word written by the host |
| ctrl_o | output | 32 | Current control word as read by the host |
| stat_evt_o | output | 1 | One-cycle management-cycle-complete status event |
| irq_o | output | 1 | One-cycle interrupt pulse when enabled in the word |

## Verification
The assertions assume that wr_en_i is a clean synchronous strobe and that the host sees ctrl_o only through the port. Under that assumption, a falling ready bit is caused only by a write, and an idle word stays stable. The bench drives every write away from the clock edge. It leaves a full completion window between writes, except in the one deliberate abandon case. This keeps each event pulse tied to a single issuing word. The sweeps cover every PHY and register pair for reads at reset, for writes, and for reads back. Expected values come from an arithmetic data pattern and the fixed-value table.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int FIELD_W = 5;
  localparam int DATA_W  = 16;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_WR   = 2'd1,
    OP_RD   = 2'd2,
    OP_RSVD = 2'd3
  } mgmt_op_e;

  // MSB first: bits 31:30, 29, 28, 27:26, 25:21, 20:16, 15:0
  typedef struct packed {
    logic [1:0]         rsvd;
    logic               ie;
    logic               rdy;
    mgmt_op_e           op;
    logic [FIELD_W-1:0] phy;
    logic [FIELD_W-1:0] regn;
    logic [DATA_W-1:0]  data;
  } ctl_word_t;
endpackage

// File: rtl/mgmt_cycle_timer.sv
module mgmt_cycle_timer #(
  parameter int LATENCY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(LATENCY - 1);
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> !busy_o); // R3
endmodule

// File: rtl/mgmt_phy_regfile.sv
module mgmt_phy_regfile #(
  parameter int PHY_AW = 5,
  parameter int REG_AW = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PHY_AW-1:0] phy_i,
  input  logic [REG_AW-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << (PHY_AW + REG_AW);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PHY_AW+REG_AW-1:0] idx;

  assign idx     = {phy_i, reg_i};
  assign rdata_o = mem_q[idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[idx] <= wdata_i;
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o == $past(wdata_i) || $past(idx) != idx); // R4
endmodule

// File: rtl/mgmt_read_shaper.sv
module mgmt_read_shaper #(
  parameter int REG_AW = 5,
  parameter int DATA_W = 16
) (
  input  logic [REG_AW-1:0] reg_i,
  input  logic [DATA_W-1:0] stored_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    case (reg_i)
      REG_AW'(0):  rdata_o = (stored_i & ~DATA_W'(16'h8200)) | DATA_W'(16'h2000);
      REG_AW'(1):  rdata_o = DATA_W'(16'h782C);
      REG_AW'(2):  rdata_o = DATA_W'(16'h0013);
      REG_AW'(3):  rdata_o = DATA_W'(16'h61D4);
      REG_AW'(5):  rdata_o = DATA_W'(16'h41E1);
      REG_AW'(6):  rdata_o = DATA_W'(16'h0001);
      REG_AW'(17): rdata_o = DATA_W'(16'h4700);
      default:     rdata_o = stored_i;
    endcase
  end
endmodule

// File: rtl/mgmt_access_unit.sv
module mgmt_access_unit
  import mgmt_pkg::*;
#(
  parameter int LATENCY = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] ctrl_o,
  output logic        stat_evt_o,
  output logic        irq_o
);
  ctl_word_t          ctl_q, wr_word;
  logic               busy, done, finish;
  logic [DATA_W-1:0]  stored, shaped;
  logic               evt_q, irq_q;

  assign wr_word = ctl_word_t'(wr_data_i);
  assign finish  = done && !wr_en_i;

  mgmt_cycle_timer #(.LATENCY(LATENCY)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(wr_en_i),
    .busy_o (busy),
    .done_o (done)
  );

  mgmt_phy_regfile #(.PHY_AW(FIELD_W), .REG_AW(FIELD_W), .DATA_W(DATA_W)) i_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (finish && ctl_q.op == OP_WR),
    .phy_i  (ctl_q.phy),
    .reg_i  (ctl_q.regn),
    .wdata_i(ctl_q.data),
    .rdata_o(stored)
  );

  mgmt_read_shaper #(.REG_AW(FIELD_W), .DATA_W(DATA_W)) i_shape (
    .reg_i   (ctl_q.regn),
    .stored_i(stored),
    .rdata_o (shaped)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q     <= '0;
      ctl_q.rdy <= 1'b1;
      evt_q     <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      evt_q <= finish;
      irq_q <= finish && ctl_q.ie;
      if (wr_en_i) begin
        ctl_q      <= wr_word;
        ctl_q.rsvd <= '0;
        ctl_q.rdy  <= 1'b0;
      end else if (done) begin
        ctl_q.rdy <= 1'b1;
        if (ctl_q.op == OP_RD) ctl_q.data <= shaped;
      end
    end
  end

  assign ctrl_o     = ctl_q;
  assign stat_evt_o = evt_q;
  assign irq_o      = irq_q;

  AST_RDY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !ctrl_o[28]); // R2
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[31:30] == 2'b00); // R2
  AST_EVT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_evt_o |=> !stat_evt_o); // R8
  AST_EVT_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_evt_o |-> ctrl_o[28] && !$past(ctrl_o[28])); // R8
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> stat_evt_o && ctrl_o[29]); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[28] && !wr_en_i |=> $stable(ctrl_o)); // R10
  AST_NOT_BUSY_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy && !wr_en_i |=> ctrl_o[28]); // R3
endmodule

// File: tb/test_mgmt_access_unit.sv
module test_mgmt_access_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] ctrl;
  logic        evt, irq;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;
  logic [15:0] model [32][32];

  always #2.5 clk = ~clk;

  mgmt_access_unit i_mgmt_access_unit (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .ctrl_o(ctrl), .stat_evt_o(evt), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic ie, logic [1:0] op, int p, int r, logic [15:0] d);
    return {2'b00, ie, 1'b0, op, p[4:0], r[4:0], d};
  endfunction

  function automatic logic [15:0] exp_rd(int r, logic [15:0] m);
    case (r)
      0:  return (m & 16'h7DFF) | 16'h2000;
      1:  return 16'h782C;
      2:  return 16'h0013;
      3:  return 16'h61D4;
      5:  return 16'h41E1;
      6:  return 16'h0001;
      17: return 16'h4700;
      default: return m;
    endcase
  endfunction

  function automatic string rd_req(int r);
    if (r == 0) return "R6";
    if (r == 1 || r == 2 || r == 3 || r == 5 || r == 6 || r == 17) return "R7";
    return "R5";
  endfunction

  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R2", ctrl, {2'b00, w[29], 1'b0, w[27:0]});
  endtask

  task automatic finish_cycle(input string req, input logic [31:0] exp_word, input logic exp_irq);
    repeat (3) @(negedge clk);
    chk("R3", {31'd0, ctrl[28]}, 32'd0);
    @(negedge clk);
    chk("R3", {31'd0, ctrl[28]}, 32'd1);
    chk("R8", {31'd0, evt}, 32'd1);
    chk("R9", {31'd0, irq}, {31'd0, exp_irq});
    chk(req, ctrl, exp_word);
    @(negedge clk);
    chk("R8", {31'd0, evt}, 32'd0);
  endtask

  task automatic do_read(input int p, input int r, input logic ie);
    logic [31:0] w;
    w = mk(ie, 2'd2, p, r, 16'hDEAD);
    issue(w);
    finish_cycle(rd_req(r), {w[31:29], 1'b1, w[27:16], exp_rd(r, model[p][r])}, ie);
  endtask

  task automatic do_write(input int p, input int r, input logic [15:0] d, input logic ie);
    logic [31:0] w;
    w = mk(ie, 2'd1, p, r, d);
    issue(w);
    finish_cycle("R4", w | 32'h1000_0000, ie);
    model[p][r] = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] w, w2;
    for (int p = 0; p < 32; p++)
      for (int r = 0; r < 32; r++) model[p][r] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", ctrl, 32'h1000_0000);
    chk("R1", {31'd0, evt}, 32'd0);
    chk("R1", {31'd0, irq}, 32'd0);

    // R1 stored contents all zero: read sweep at reset
    for (int p = 0; p < 32; p++)
      for (int r = 0; r < 32; r++) do_read(p, r, 1'b0);

    // write sweep, arithmetic pattern, IE alternating by PHY
    for (int p = 0; p < 32; p++)
      for (int r = 0; r < 32; r++)
        do_write(p, r, 16'((p * 1103 + r * 97 + 16'h5A5A) ^ (r << 11)), p[0]);

    // read-back sweep, IE alternating by register
    for (int p = 0; p < 32; p++)
      for (int r = 0; r < 32; r++) do_read(p, r, r[0]);

    // R6 all-ones in register 0
    do_write(9, 0, 16'hFFFF, 1'b0);
    do_read(9, 0, 1'b1);

    // R10 opcodes 0 and 3 leave storage untouched
    w = mk(1'b1, 2'd0, 4, 7, 16'h1234);
    issue(w);
    finish_cycle("R10", w | 32'h1000_0000, 1'b1);
    w = mk(1'b0, 2'd3, 4, 7, 16'h4321);
    issue(w);
    finish_cycle("R10", w | 32'h1000_0000, 1'b0);
    do_read(4, 7, 1'b0);

    // R11 pending write abandoned by a new write
    w  = mk(1'b1, 2'd1, 1, 9, 16'hAAAA);
    w2 = mk(1'b0, 2'd1, 1, 10, 16'h5555);
    issue(w);
    @(negedge clk);
    chk("R11", {31'd0, evt}, 32'd0);
    issue(w2);
    finish_cycle("R11", w2 | 32'h1000_0000, 1'b0);
    model[1][10] = 16'h5555;
    do_read(1, 9, 1'b0);
    do_read(1, 10, 1'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule